// File: doc/BRIEF.md
# Eight-Line Programmable Interrupt Controller

This block gathers eight interrupt lines into one request to a processor. Each line can be set to edge or level capture. Pending requests pass through a mask and are ranked against the levels already in service. Ranking starts from a base line that can rotate. The processor sees a single `int_req` output. When it samples `ack`, the block returns the winning line number and an 8-bit vector built from a programmable base.

Software drives the block through a byte-wide port with two addresses. A write at address 0 with bit 4 set starts a multi-word setup sequence. Other address-0 writes are operation commands: end-of-interrupt variants, priority rotation, read-select, special mask and poll. In normal operation, address 1 holds the mask. A separate strobe writes the trigger-mode byte.

Everything is synchronous to one clock. All control pins are plain single-cycle strobes with no back-pressure: a write, read or acknowledge takes effect at the rising edge where its strobe is high. `rdata`, `ack_line` and `ack_vec` are combinational views of the current state, so they are valid in the same cycle as the strobe. Software issues at most one of write, poll-read and acknowledge per cycle.

Top module: `irq_ctl8`

## Requirements
- R1: After `rst_n` is released, `int_req` is low and the request, mask, in-service and trigger bytes all read zero.
- R2: A line whose trigger bit is 0 latches a request only on a low-to-high change from its level in the previous cycle. If the line stays high after it is acknowledged, no new request is raised.
- R3: A line whose trigger bit is 1 has a request bit that follows its input one cycle later, and acknowledge does not clear it. A trigger write stores `wdata & TRIG_MASK`. The trigger byte survives the setup sequence.
- R4: Rank p belongs to line (p + base) mod 8, and rank 0 is the most urgent. `int_req` is high only outside the setup sequence, and only when the best unmasked pending rank is strictly lower than the best in-service rank.
- R5: When `ack` is high and `int_req` is high, `ack_line` is the winning line and `ack_vec` is {vector base bits 7:3, line}. Without auto-EOI the line's in-service bit is set. An edge-line request bit is cleared. When `int_req` is low, `ack_line` reads 7 and the acknowledge changes nothing.
- R6: With auto-EOI on, acknowledge sets no in-service bit. If rotate-on-auto-EOI is also on, the base becomes (line + 1) mod 8.
- R7: An address-0 write with bit 4 set clears every register except the trigger byte and stores bit 0 as "fourth word expected". The next address-1 write sets the vector base from bits 7:3. The write after that is ignored. A fourth word, when expected, sets fully-nested mode from bit 4 and auto-EOI from bit 1. `int_req` stays low until the sequence ends.
- R8: In normal mode an address-1 write loads the mask. Address-1 reads return the mask.
- R9: An address-0 write with bits 4:3 = 01 works as follows: bit 2 arms poll; bit 1 makes bit 0 the read select (1 = in-service, 0 = request); bit 6 makes bit 5 the special-mask flag. Address-0 reads follow the read select. With special mask on, in-service bits of masked lines do not block lower-priority requests.
- R10: An address-0 write with bits 4:3 = 00 decodes bits 7:5 as follows. Code 1 clears the best in-service bit. Code 5 does the same and sets base = line + 1. Code 3 clears the in-service bit named in bits 2:0. Code 7 does the same and sets base = that line + 1. Code 6 sets base = bits 2:0 + 1. Codes 0 and 4 clear or set rotate-on-auto-EOI. Code 2 does nothing.
- R11: A read while poll is armed returns the winning line, or 7 if there is none. It clears that line's request and in-service bits and disarms poll.
- R12: With fully-nested mode on, the in-service bit of line `CASCADE_LINE` is ignored when deciding whether a request outranks the lines in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Interrupt lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register address |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (needed only for poll side effects) |
| rdata | output | 8 | Read data for `addr` |
| trig_wr | input | 1 | Trigger-mode byte write strobe (takes `wdata`) |
| trig_q | output | 8 | Trigger-mode byte, 1 = level |
| int_req | output | 1 | Interrupt request to processor |
| ack | input | 1 | Acknowledge strobe |
| ack_line | output | 3 | Winning line, 7 when none |
| ack_vec | output | 8 | Vector base joined with `ack_line` |

## Verification
The bench goes after cases that one wrong comparison or one wrong clear would break:
- An edge line held high across its acknowledge must not request again. A design that re-arms on level would interrupt forever.
- A level line must come back after its end-of-interrupt. A design that clears it on acknowledge would lose the request.
- Equal-rank cases must stay quiet. Using `<=` in place of `<` would re-enter the current level.
- After a rotation, line 0 is no longer the most urgent. A design that ignores the base would pick line 0.
- A poll read with nothing pending must return 7, clear nothing and disarm poll.
- Through the setup sequence, the three-word form must go straight back to normal mode, so the next address-1 write lands in the mask. The trigger byte must survive.

A long random phase then mixes all commands against a behavioural model.

// File: rtl/irq_ctl8_pkg.sv
package irq_ctl8_pkg;
  localparam int unsigned NL = 8;               // interrupt lines
  localparam int unsigned DW = 8;               // register port width
  localparam int unsigned LW = $clog2(NL);      // line index width
  localparam int unsigned RW = LW + 1;          // rank width, value NL = none

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_VEC  = 2'd1,
    ST_SKIP = 2'd2,
    ST_OPT  = 2'd3
  } setup_st_t;

  // operation command codes in wdata[7:5]
  localparam logic [2:0] OP_RAE_OFF = 3'd0;
  localparam logic [2:0] OP_EOI     = 3'd1;
  localparam logic [2:0] OP_SEOI    = 3'd3;
  localparam logic [2:0] OP_RAE_ON  = 3'd4;
  localparam logic [2:0] OP_REOI    = 3'd5;
  localparam logic [2:0] OP_SETPRI  = 3'd6;
  localparam logic [2:0] OP_RSEOI   = 3'd7;
endpackage

// File: rtl/irq_ctl8_reqlatch.sv
module irq_ctl8_reqlatch
  import irq_ctl8_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] irq_in,
  input  logic [NL-1:0] trig,
  input  logic [NL-1:0] clr,
  input  logic          init_clr,
  output logic [NL-1:0] irr
);
  for (genvar i = 0; i < NL; i++) begin : g_line
    logic req_q, prev_q;
    always_ff @(posedge clk) begin
      if (!rst_n || init_clr) begin
        req_q  <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        prev_q <= irq_in[i];
        if (trig[i]) req_q <= irq_in[i];
        else         req_q <= (req_q & ~clr[i]) | (irq_in[i] & ~prev_q);
      end
    end
    assign irr[i] = req_q;
  end
endmodule

// File: rtl/irq_ctl8_rank.sv
module irq_ctl8_rank
  import irq_ctl8_pkg::*;
(
  input  logic [NL-1:0] mask,
  input  logic [LW-1:0] base,
  output logic [RW-1:0] rank
);
  always_comb begin
    rank = RW'(NL);
    for (int p = NL - 1; p >= 0; p--) begin
      if (mask[base + LW'(p)]) rank = RW'(p);
    end
  end
endmodule

// File: rtl/irq_ctl8.sv
module irq_ctl8
  import irq_ctl8_pkg::*;
#(
  parameter logic [7:0] TRIG_MASK    = 8'hF8,
  parameter int unsigned CASCADE_LINE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] irq_in,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  output logic [DW-1:0] rdata,
  input  logic          trig_wr,
  output logic [NL-1:0] trig_q,
  output logic          int_req,
  input  logic          ack,
  output logic [LW-1:0] ack_line,
  output logic [DW-1:0] ack_vec
);
  localparam logic [NL-1:0] CASC_BIT = NL'(1) << CASCADE_LINE;
  localparam int unsigned   VBW      = DW - LW;

  logic [NL-1:0]  irr, imr_q, isr_q;
  logic [LW-1:0]  base_q, base_nxt;
  logic [VBW-1:0] vbase_q;
  logic           rsel_q, poll_q, smm_q, aeoi_q, rae_q, rae_nxt, sfnm_q, need4_q;
  setup_st_t      st_q;

  // ranking
  logic [NL-1:0] pend, isr_cmp, isr_set, isr_clr, irr_clr;
  logic [RW-1:0] pend_rank, cmp_rank, isr_rank;
  logic [LW-1:0] pend_line, isr_line;
  logic          winner, isr_any;

  assign pend    = irr & ~imr_q;
  assign isr_cmp = isr_q & ~(sfnm_q ? CASC_BIT : '0) & ~(smm_q ? imr_q : '0);

  irq_ctl8_rank u_pend (.mask(pend),    .base(base_q), .rank(pend_rank));
  irq_ctl8_rank u_cmp  (.mask(isr_cmp), .base(base_q), .rank(cmp_rank));
  irq_ctl8_rank u_isr  (.mask(isr_q),   .base(base_q), .rank(isr_rank));

  assign pend_line = base_q + pend_rank[LW-1:0];
  assign isr_line  = base_q + isr_rank[LW-1:0];
  assign isr_any   = (isr_rank != RW'(NL));
  assign winner    = (st_q == ST_RUN) && (pend_rank < cmp_rank);

  assign int_req  = winner;
  assign ack_line = winner ? pend_line : LW'(NL - 1);
  assign ack_vec  = {vbase_q, ack_line};

  // strobe decode
  logic do_ack, do_poll, wr0, wr1, is_init, is_ocw3, is_ocw2;
  assign do_ack  = ack && winner;
  assign do_poll = rd_en && poll_q;
  assign wr0     = wr_en && !addr;
  assign wr1     = wr_en && addr;
  assign is_init = wr0 && wdata[4];
  assign is_ocw3 = wr0 && !wdata[4] && wdata[3];
  assign is_ocw2 = wr0 && !wdata[4] && !wdata[3];

  // request latch
  assign irr_clr = ((do_ack || (do_poll && winner)) ? (NL'(1) << pend_line) : '0);

  irq_ctl8_reqlatch u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trig(trig_q),
    .clr(irr_clr), .init_clr(is_init), .irr(irr)
  );

  // in-service and priority base next state
  always_comb begin
    isr_set  = '0;
    isr_clr  = '0;
    base_nxt = base_q;
    rae_nxt  = rae_q;
    if (do_ack) begin
      if (!aeoi_q)    isr_set  = NL'(1) << pend_line;
      else if (rae_q) base_nxt = pend_line + LW'(1);
    end
    if (do_poll && winner) isr_clr = NL'(1) << pend_line;
    if (is_ocw2) begin
      unique case (wdata[7:5])
        OP_RAE_OFF: rae_nxt = 1'b0;
        OP_RAE_ON:  rae_nxt = 1'b1;
        OP_EOI:     if (isr_any) isr_clr = isr_clr | (NL'(1) << isr_line);
        OP_REOI: begin
          if (isr_any) begin
            isr_clr  = isr_clr | (NL'(1) << isr_line);
            base_nxt = isr_line + LW'(1);
          end
        end
        OP_SEOI:    isr_clr = isr_clr | (NL'(1) << wdata[LW-1:0]);
        OP_SETPRI:  base_nxt = wdata[LW-1:0] + LW'(1);
        OP_RSEOI: begin
          isr_clr  = isr_clr | (NL'(1) << wdata[LW-1:0]);
          base_nxt = wdata[LW-1:0] + LW'(1);
        end
        default: ;
      endcase
    end
  end

  // control registers
  always_ff @(posedge clk) begin
    if (!rst_n || is_init) begin
      imr_q   <= '0;
      isr_q   <= '0;
      base_q  <= '0;
      vbase_q <= '0;
      rsel_q  <= 1'b0;
      poll_q  <= 1'b0;
      smm_q   <= 1'b0;
      aeoi_q  <= 1'b0;
      rae_q   <= 1'b0;
      sfnm_q  <= 1'b0;
      need4_q <= rst_n ? wdata[0] : 1'b0;
      st_q    <= rst_n ? ST_VEC : ST_RUN;
    end else begin
      isr_q  <= (isr_q | isr_set) & ~isr_clr;
      base_q <= base_nxt;
      rae_q  <= rae_nxt;
      if (do_poll) poll_q <= 1'b0;
      if (is_ocw3) begin
        if (wdata[2]) poll_q <= 1'b1;
        if (wdata[1]) rsel_q <= wdata[0];
        if (wdata[6]) smm_q  <= wdata[5];
      end
      if (wr1) begin
        unique case (st_q)
          ST_RUN:  imr_q <= wdata;
          ST_VEC: begin
            vbase_q <= wdata[DW-1:LW];
            st_q    <= ST_SKIP;
          end
          ST_SKIP: st_q <= need4_q ? ST_OPT : ST_RUN;
          ST_OPT: begin
            sfnm_q <= wdata[4];
            aeoi_q <= wdata[1];
            st_q   <= ST_RUN;
          end
          default: st_q <= ST_RUN;
        endcase
      end
    end
  end

  // trigger byte: only the power-on reset clears it
  always_ff @(posedge clk) begin
    if (!rst_n)       trig_q <= '0;
    else if (trig_wr) trig_q <= wdata & TRIG_MASK;
  end

  // read path
  always_comb begin
    if (do_poll)   rdata = winner ? DW'(pend_line) : DW'(NL - 1);
    else if (addr) rdata = imr_q;
    else           rdata = rsel_q ? isr_q : irr;
  end
endmodule

// File: rtl/irq_ctl8_chk.sv
module irq_ctl8_chk #(
  parameter logic [7:0] TRIG_MASK = 8'hF8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       addr,
  input logic [7:0] wdata,
  input logic       rd_en,
  input logic       ack,
  input logic       int_req,
  input logic [2:0] ack_line,
  input logic [7:0] irr,
  input logic [7:0] imr,
  input logic [7:0] isr,
  input logic       poll,
  input logic       aeoi,
  input logic [7:0] trig_q
);
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!int_req && isr == 8'h00 && imr == 8'h00 && trig_q == 8'h00));

  a_r4_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> ((irr & ~imr) != 8'h00));

  a_r5_ack_marks_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_req && !aeoi && !wr_en && !rd_en) |=> isr[$past(ack_line)]);

  a_r11_poll_once: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && poll && !wr_en) |=> !poll);

  a_r7_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4]) |=> (!int_req && isr == 8'h00 && imr == 8'h00 && irr == 8'h00));

  a_r3_trig_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q & ~TRIG_MASK) == 8'h00);
endmodule

bind irq_ctl8 irq_ctl8_chk #(.TRIG_MASK(TRIG_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rd_en(rd_en), .ack(ack), .int_req(int_req), .ack_line(ack_line),
  .irr(irr), .imr(imr_q), .isr(isr_q), .poll(poll_q), .aeoi(aeoi_q),
  .trig_q(trig_q)
);

// File: tb/sim_irq_ctl8.sv
module sim_irq_ctl8;
  localparam int CLK_P = 10;
  localparam logic [7:0] TMASK = 8'hF8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] irq_in = '0, wdata = '0, rdata, trig_q, ack_vec;
  logic wr_en = 0, addr = 0, rd_en = 0, trig_wr = 0, ack = 0, int_req;
  logic [2:0] ack_line;

  always #(CLK_P/2) clk = ~clk;

  irq_ctl8 u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .trig_wr(trig_wr),
    .trig_q(trig_q), .int_req(int_req), .ack(ack), .ack_line(ack_line),
    .ack_vec(ack_vec)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";
  logic [7:0] lines = '0;
  logic [7:0] s_rdata, s_vec;
  logic [2:0] s_line;
  logic s_int;

  // behavioural model state
  logic [7:0] m_irr = 0, m_last = 0, m_imr = 0, m_isr = 0, m_trig = 0;
  int m_base = 0, m_vb = 0, m_st = 0;
  bit m_rsel = 0, m_poll = 0, m_smm = 0, m_aeoi = 0, m_rae = 0, m_sfnm = 0, m_n4 = 0;

  function automatic int rank(logic [7:0] m, int b);
    for (int p = 0; p < 8; p++) if (m[(b + p) % 8]) return p;
    return 8;
  endfunction

  function automatic void judge(output bit win, output int wl);
    logic [7:0] cm;
    int rp;
    cm = m_isr;
    if (m_sfnm) cm[2] = 1'b0;
    if (m_smm) cm = cm & ~m_imr;
    rp = rank(m_irr & ~m_imr, m_base);
    win = (m_st == 0) && (rp < rank(cm, m_base));
    wl = (m_base + rp) % 8;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_step(bit wr, bit a, logic [7:0] wd, bit rd, bit ak, bit tw);
    bit win;
    int wl, nb;
    logic [7:0] clr, trig_old, seti, clri;
    judge(win, wl);
    trig_old = m_trig;
    if (tw) m_trig = wd & TMASK;
    if (wr && !a && wd[4]) begin
      m_irr = 0; m_last = 0; m_imr = 0; m_isr = 0; m_base = 0; m_vb = 0;
      m_rsel = 0; m_poll = 0; m_smm = 0; m_aeoi = 0; m_rae = 0; m_sfnm = 0;
      m_n4 = wd[0]; m_st = 1;
      return;
    end
    clr = 0; seti = 0; clri = 0; nb = m_base;
    if (ak && win) begin
      clr[wl] = 1'b1;
      if (!m_aeoi) seti[wl] = 1'b1;
      else if (m_rae) nb = (wl + 1) % 8;
    end
    if (rd && m_poll) begin
      m_poll = 0;
      if (win) begin clr[wl] = 1'b1; clri[wl] = 1'b1; end
    end
    if (wr && !a && wd[3]) begin
      if (wd[2]) m_poll = 1;
      if (wd[1]) m_rsel = wd[0];
      if (wd[6]) m_smm = wd[5];
    end else if (wr && !a) begin
      int hi;
      hi = rank(m_isr, m_base);
      case (int'(wd[7:5]))
        0: m_rae = 0;
        4: m_rae = 1;
        1: if (hi < 8) clri[(m_base + hi) % 8] = 1'b1;
        5: if (hi < 8) begin clri[(m_base + hi) % 8] = 1'b1; nb = (m_base + hi + 1) % 8; end
        3: clri[wd[2:0]] = 1'b1;
        6: nb = (int'(wd[2:0]) + 1) % 8;
        7: begin clri[wd[2:0]] = 1'b1; nb = (int'(wd[2:0]) + 1) % 8; end
        default: ;
      endcase
    end
    if (wr && a) begin
      case (m_st)
        0: m_imr = wd;
        1: begin m_vb = int'(wd[7:3]); m_st = 2; end
        2: m_st = m_n4 ? 3 : 0;
        default: begin m_sfnm = wd[4]; m_aeoi = wd[1]; m_st = 0; end
      endcase
    end
    m_isr = (m_isr | seti) & ~clri;
    m_base = nb;
    for (int i = 0; i < 8; i++) begin
      if (trig_old[i]) m_irr[i] = lines[i];
      else m_irr[i] = (m_irr[i] & ~clr[i]) | (lines[i] & ~m_last[i]);
    end
    m_last = lines;
  endtask

  task automatic step(bit wr = 0, bit a = 0, logic [7:0] wd = 0, bit rd = 0, bit ak = 0, bit tw = 0);
    bit win;
    int wl, erd;
    wr_en = wr; addr = a; wdata = wd; rd_en = rd; ack = ak; trig_wr = tw; irq_in = lines;
    #(CLK_P/4);
    judge(win, wl);
    if (rd && m_poll) erd = win ? wl : 7;
    else if (a) erd = m_imr;
    else erd = m_rsel ? m_isr : m_irr;
    chk(tag, "int_req", int'(int_req), int'(win));
    chk(tag, "ack_line", int'(ack_line), win ? wl : 7);
    chk(tag, "ack_vec", int'(ack_vec), m_vb * 8 + (win ? wl : 7));
    chk(tag, "rdata", int'(rdata), erd);
    chk(tag, "trig_q", int'(trig_q), int'(m_trig));
    s_rdata = rdata; s_vec = ack_vec; s_line = ack_line; s_int = int_req;
    @(posedge clk);
    model_step(wr, a, wd, rd, ak, tw);
    @(negedge clk);
  endtask

  task automatic w0(logic [7:0] v); step(.wr(1), .a(0), .wd(v)); endtask
  task automatic w1(logic [7:0] v); step(.wr(1), .a(1), .wd(v)); endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    tag = "R1";
    step(); step(.a(1));
    chk("R1", "int_req after reset", int'(s_int), 0);
    chk("R1", "mask after reset", int'(s_rdata), 0);
    // R7 four-word setup, vector base 0x40
    tag = "R7";
    w0(8'h11); w1(8'h40); w1(8'h00); w1(8'h00);
    // R3 trigger masking
    tag = "R3";
    step(.wd(8'hFF), .tw(1));
    chk("R3", "trig masked", int'(trig_q), 8'hF8);
    // R2 edge line 1
    tag = "R2";
    lines[1] = 1'b1; step(); step();
    chk("R2", "edge raises int_req", int'(s_int), 1);
    step(.ak(1));
    chk("R5", "ack line", int'(s_line), 1);
    chk("R5", "ack vector", int'(s_vec), 8'h41);
    step();
    chk("R2", "held line no re-request", int'(s_int), 0);
    w0(8'h20); step();
    chk("R2", "held line after EOI", int'(s_int), 0);
    lines[1] = 1'b0; step(); lines[1] = 1'b1; step(); step();
    chk("R2", "new edge requests", int'(s_int), 1);
    step(.ak(1)); w0(8'h20); lines[1] = 1'b0;
    // R3 level line 5
    tag = "R3";
    lines[5] = 1'b1; step(); step(.ak(1)); step();
    chk("R3", "level blocked in service", int'(s_int), 0);
    w0(8'h20); step();
    chk("R3", "level persists after EOI", int'(s_int), 1);
    lines[5] = 1'b0; step(); step();
    chk("R3", "level follows input", int'(s_int), 0);
    // R4 / R8 priority and mask
    tag = "R4";
    lines = 8'h24; step(); step();
    chk("R4", "line 2 beats 5", int'(s_line), 2);
    tag = "R8";
    w1(8'h04); step(.a(1));
    chk("R8", "mask readback", int'(s_rdata), 8'h04);
    step(.ak(1));
    tag = "R4";
    lines[0] = 1'b1; step(); step(.ak(1)); step(); step();
    // R9 read select and special mask
    tag = "R9";
    w0(8'h0B); step(); w0(8'h0A); step();
    w1(8'h21); w0(8'h68); step(); step(); w0(8'h48); step();
    // R10 end-of-interrupt and rotation family
    tag = "R10";
    w0(8'hC4); step(); w0(8'h65); step(); w0(8'hA0); step(); w0(8'hE0); step();
    w0(8'h40); step(); w0(8'h20); w0(8'h20); w0(8'h20); step(); w1(8'h00); step();
    // R11 poll
    tag = "R11";
    lines = 8'h00; step(); w0(8'h0C); step(.rd(1)); step(.rd(1));
    w1(8'hFF); w0(8'h0C); step(.rd(1));
    chk("R11", "empty poll returns 7", int'(s_rdata), 7);
    w1(8'h00); lines[6] = 1'b1; step(); w0(8'h0C); step(.rd(1)); step();
    lines = 8'h00; step();
    // R6 auto-EOI with rotation
    tag = "R6";
    w0(8'h13); w1(8'h80); w1(8'h00); w1(8'h02); w0(8'h80);
    lines = 8'h0A; step(); step(.ak(1)); step(); step(.ak(1)); step();
    w0(8'h00); lines = 8'h00; step(); lines = 8'h02; step(); step(.ak(1)); step();
    // R12 fully-nested handling of the cascade line
    tag = "R12";
    lines = 8'h00; w0(8'h11); w1(8'h08); w1(8'h00); w1(8'h10);
    lines[2] = 1'b1; step(); step(.ak(1)); lines[2] = 1'b0; step(); lines[2] = 1'b1; step(); step();
    chk("R12", "cascade line re-enters", int'(s_int), 1);
    // R7 three-word setup, then mask
    tag = "R7";
    lines = 8'h00; w0(8'h10); step(); w1(8'h18); w1(8'h00); w1(8'h55); step(.a(1));
    chk("R7", "mask after 3-word setup", int'(s_rdata), 8'h55);
    chk("R3", "trigger kept over setup", int'(trig_q), 8'hF8);
    w1(8'h00);
    // mixed random traffic
    tag = "R4";
    for (int n = 0; n < 3000; n++) begin
      int op;
      logic [7:0] v;
      op = int'($urandom_range(0, 19));
      v = 8'($urandom);
      if ($urandom_range(0, 3) == 0) lines[$urandom_range(0, 7)] ^= 1'b1;
      case (op)
        0, 1, 2, 3: step(.ak(1));
        4, 5:       step(.rd(1), .a(v[0]));
        6, 7:       w1(v);
        8, 9, 10:   w0({v[7:5], 2'b00, v[2:0]});
        11:         w0({v[7:5], 2'b01, v[2:0]});
        12:         if (v[7:4] == 0) w0({v[7:5], 1'b1, v[3:0]}); else step();
        13:         step(.wd(v), .tw(1));
        default:    step();
      endcase
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule